// File: doc/BRIEF.md
# Flash Security Access Controller

This block decides, one request at a time, whether the debug port or the CPU may run a flash command. The commands are read, write, page erase and global erase. The decision uses three pieces of state. The first is a lock bit that the CPU can only set. The second is a one-time fuse that arms that lock. The third is a one-time fuse that shuts the debug port off for good. A request is answered in the same cycle it is presented, with either a grant or a block.

The lock has an effect only when the arming fuse was blown before the last reset. While the lock is in effect, the debug port may do nothing except a global erase. Neither port may write or page-erase flash page zero. Every granted global erase, from either port, produces a one-cycle pulse that tells the data RAM to clear itself. This happens whether the lock is set or not.

Both fuse inputs are captured while reset is asserted and are held after reset is released. A fuse change after reset therefore has no effect until the next reset. The lock bit always returns to zero on reset. After a global erase and a reset, the debug port has full access again.

Top module: `flash_sec_ctrl`

## Requirements
- R1: After reset with both fuses unblown, every valid command (1 = read, 2 = write, 3 = page erase, 4 = global erase) on either port is granted for any page.
- R2: The lock bit is set by a CPU lock write with data 1. A lock write with data 0 leaves the bit unchanged. A set lock takes effect in the cycle after the write.
- R3: While the arming fuse (`fuse_arm_i`) is unblown, setting the lock changes no grant decision.
- R4: While the lock is in effect (lock set and arming fuse blown), the debug port is granted only command 4 (global erase). Every other debug command is blocked.
- R5: While the lock is in effect, write (2) and page erase (3) to page 0 are blocked for both ports. The CPU is still granted those commands on nonzero pages, and is granted read and global erase on every page.
- R6: `xram_clear` is high for exactly the one cycle after a cycle in which a global erase was granted on either port, with or without the lock.
- R7: Reset clears the lock bit, so full debug access returns after a reset.
- R8: While the debug-kill fuse captured at reset is blown, every debug request is blocked. CPU decisions are unaffected.
- R9: Fuse inputs are captured during reset. Changes to them after reset is released do not alter decisions until the next reset.
- R10: Grant and block are never both high on a port. Both are low when there is no request. A command code of 0 or 5 to 7 is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; fuses are captured while it is low |
| lock_wr_en | input | 1 | CPU write strobe for the lock bit |
| lock_wr_data | input | 1 | Value written; only 1 has an effect |
| fuse_arm_i | input | 1 | Fuse that arms the lock bit (1 = blown) |
| fuse_kill_i | input | 1 | Fuse that disables the debug port (1 = blown) |
| dbg_req | input | 1 | Debug command request |
| dbg_cmd | input | 3 | Debug command code |
| dbg_page | input | PAGE_W | Debug target flash page |
| cpu_req | input | 1 | CPU command request |
| cpu_cmd | input | 3 | CPU command code |
| cpu_page | input | PAGE_W | CPU target flash page |
| dbg_grant | output | 1 | Debug request allowed |
| dbg_block | output | 1 | Debug request refused |
| cpu_grant | output | 1 | CPU request allowed |
| cpu_block | output | 1 | CPU request refused |
| xram_clear | output | 1 | One-cycle data RAM clear pulse |

## Verification
Some properties are checked on every clock cycle:
- grant and block are exclusive on each port, and both stay quiet when there is no request;
- the lock bit never falls outside reset, and the captured fuses never change outside reset;
- no debug grant happens while the kill fuse is held;
- under the lock, only a global erase is granted to the debug port, and nothing touches page zero;
- the clear pulse lines up with granted global erases.

The bench runs a sweep of every command code and page on both ports for each fuse combination. It repeats the sweep with the lock clear and with the lock set. Only those scenarios can show the following:
- that a lock write of 0 changes nothing;
- that fuse changes after reset are ignored;
- that a reset restores full debug access;
- that the lock without the arming fuse leaves every decision as it was.

// File: rtl/flash_sec_pkg.sv
package flash_sec_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE   = 3'd0,
        CMD_READ   = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_PERASE = 3'd3,
        CMD_GERASE = 3'd4
    } flash_cmd_e;

    typedef struct packed {
        logic lock;
        logic arm;
        logic kill;
        logic xclr;
    } sec_state_t;

endpackage

// File: rtl/flash_sec_state.sv
module flash_sec_state (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_wr_en,
    input  logic lock_wr_data,
    input  logic fuse_arm_i,
    input  logic fuse_kill_i,
    input  logic gerase_granted_i,
    output logic lock_q,
    output logic arm_q,
    output logic kill_q,
    output logic xclr_q
);
    import flash_sec_pkg::*;

    sec_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lock = st_q.lock | (lock_wr_en & lock_wr_data);
        st_d.xclr = gerase_granted_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock <= 1'b0;
            st_q.arm  <= fuse_arm_i;
            st_q.kill <= fuse_kill_i;
            st_q.xclr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q = st_q.lock;
    assign arm_q  = st_q.arm;
    assign kill_q = st_q.kill;
    assign xclr_q = st_q.xclr;

endmodule

// File: rtl/flash_sec_arbiter.sv
module flash_sec_arbiter #(
    parameter bit IS_DEBUG = 1'b0,
    parameter int PAGE_W   = 4
) (
    input  logic                            req_i,
    input  logic [flash_sec_pkg::CMD_W-1:0] cmd_i,
    input  logic [PAGE_W-1:0]               page_i,
    input  logic                            locked_i,
    input  logic                            kill_i,
    output logic                            grant_o,
    output logic                            block_o
);
    import flash_sec_pkg::*;

    logic valid_cmd;
    logic page0_mod;
    logic allow;

    always_comb begin
        valid_cmd = (cmd_i >= CMD_READ) && (cmd_i <= CMD_GERASE);
        page0_mod = ((cmd_i == CMD_WRITE) || (cmd_i == CMD_PERASE)) && (page_i == '0);
        allow     = valid_cmd;
        if (locked_i && page0_mod) begin
            allow = 1'b0;
        end
        if (IS_DEBUG) begin
            if (kill_i) begin
                allow = 1'b0;
            end
            if (locked_i && (cmd_i != CMD_GERASE)) begin
                allow = 1'b0;
            end
        end
        grant_o = req_i & allow;
        block_o = req_i & ~allow;
    end

endmodule

// File: rtl/flash_sec_ctrl.sv
module flash_sec_ctrl #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr_en,
    input  logic              lock_wr_data,
    input  logic              fuse_arm_i,
    input  logic              fuse_kill_i,
    input  logic              dbg_req,
    input  logic [2:0]        dbg_cmd,
    input  logic [PAGE_W-1:0] dbg_page,
    input  logic              cpu_req,
    input  logic [2:0]        cpu_cmd,
    input  logic [PAGE_W-1:0] cpu_page,
    output logic              dbg_grant,
    output logic              dbg_block,
    output logic              cpu_grant,
    output logic              cpu_block,
    output logic              xram_clear
);
    import flash_sec_pkg::*;

    localparam int NPORT = 2;

    logic lock_q, arm_q, kill_q, xclr_q;
    logic locked;
    logic gerase_granted;

    logic [NPORT-1:0]       req_a, grant_a, block_a;
    logic [CMD_W-1:0]       cmd_a  [NPORT];
    logic [PAGE_W-1:0]      page_a [NPORT];

    assign req_a     = {cpu_req, dbg_req};
    assign cmd_a[0]  = dbg_cmd;
    assign cmd_a[1]  = cpu_cmd;
    assign page_a[0] = dbg_page;
    assign page_a[1] = cpu_page;

    assign locked = lock_q & arm_q;

    flash_sec_state u_state (
        .clk              (clk),
        .rst_n            (rst_n),
        .lock_wr_en       (lock_wr_en),
        .lock_wr_data     (lock_wr_data),
        .fuse_arm_i       (fuse_arm_i),
        .fuse_kill_i      (fuse_kill_i),
        .gerase_granted_i (gerase_granted),
        .lock_q           (lock_q),
        .arm_q            (arm_q),
        .kill_q           (kill_q),
        .xclr_q           (xclr_q)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        flash_sec_arbiter #(
            .IS_DEBUG (g == 0),
            .PAGE_W   (PAGE_W)
        ) u_arb (
            .req_i    (req_a[g]),
            .cmd_i    (cmd_a[g]),
            .page_i   (page_a[g]),
            .locked_i (locked),
            .kill_i   (kill_q),
            .grant_o  (grant_a[g]),
            .block_o  (block_a[g])
        );
    end

    assign gerase_granted = (grant_a[0] && (cmd_a[0] == CMD_GERASE))
                          | (grant_a[1] && (cmd_a[1] == CMD_GERASE));

    assign dbg_grant  = grant_a[0];
    assign dbg_block  = block_a[0];
    assign cpu_grant  = grant_a[1];
    assign cpu_block  = block_a[1];
    assign xram_clear = xclr_q;

endmodule

// File: rtl/flash_sec_chk.sv
module flash_sec_chk #(
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_req,
    input logic [2:0]        dbg_cmd,
    input logic              cpu_req,
    input logic [2:0]        cpu_cmd,
    input logic [PAGE_W-1:0] dbg_page,
    input logic [PAGE_W-1:0] cpu_page,
    input logic              dbg_grant,
    input logic              dbg_block,
    input logic              cpu_grant,
    input logic              cpu_block,
    input logic              xram_clear,
    input logic              lock_q,
    input logic              arm_q,
    input logic              kill_q
);
    logic eff;
    logic ge_any;
    assign eff    = lock_q & arm_q;
    assign ge_any = (dbg_grant && dbg_cmd == 3'd4) || (cpu_grant && cpu_cmd == 3'd4);

    assert_excl_dbg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbg_grant && dbg_block));
    assert_excl_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_grant && cpu_block));
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_req |-> !(dbg_grant || dbg_block)) and (!cpu_req |-> !(cpu_grant || cpu_block)));
    assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    assert_fuse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(arm_q) && $stable(kill_q)));
    assert_kill_dbg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kill_q |-> !dbg_grant);
    assert_dbg_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eff && dbg_grant) |-> (dbg_cmd == 3'd4));
    assert_page0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff && cpu_grant && (cpu_cmd == 3'd2 || cpu_cmd == 3'd3)) |-> (cpu_page != '0));
    assert_xclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ge_any |=> xram_clear);
    assert_xclr_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ge_any) |=> !xram_clear);
endmodule

bind flash_sec_ctrl flash_sec_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_req    (dbg_req),
    .dbg_cmd    (dbg_cmd),
    .cpu_req    (cpu_req),
    .cpu_cmd    (cpu_cmd),
    .dbg_page   (dbg_page),
    .cpu_page   (cpu_page),
    .dbg_grant  (dbg_grant),
    .dbg_block  (dbg_block),
    .cpu_grant  (cpu_grant),
    .cpu_block  (cpu_block),
    .xram_clear (xram_clear),
    .lock_q     (lock_q),
    .arm_q      (arm_q),
    .kill_q     (kill_q)
);

// File: tb/tb_flash_sec_ctrl.sv
module tb_flash_sec_ctrl;
    localparam int PAGE_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_wr_en = 1'b0, lock_wr_data = 1'b0;
    logic fuse_arm_i = 1'b0, fuse_kill_i = 1'b0;
    logic dbg_req = 1'b0, cpu_req = 1'b0;
    logic [2:0] dbg_cmd = '0, cpu_cmd = '0;
    logic [PAGE_W-1:0] dbg_page = '0, cpu_page = '0;
    logic dbg_grant, dbg_block, cpu_grant, cpu_block, xram_clear;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_sec_ctrl #(.PAGE_W(PAGE_W)) dut (
        .clk(clk), .rst_n(rst_n), .lock_wr_en(lock_wr_en), .lock_wr_data(lock_wr_data),
        .fuse_arm_i(fuse_arm_i), .fuse_kill_i(fuse_kill_i),
        .dbg_req(dbg_req), .dbg_cmd(dbg_cmd), .dbg_page(dbg_page),
        .cpu_req(cpu_req), .cpu_cmd(cpu_cmd), .cpu_page(cpu_page),
        .dbg_grant(dbg_grant), .dbg_block(dbg_block),
        .cpu_grant(cpu_grant), .cpu_block(cpu_block), .xram_clear(xram_clear)
    );

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic bit dbg_ok(input int cmd, input bit arm, input bit kill, input bit lk);
        if (cmd < 1 || cmd > 4) return 0;
        if (kill) return 0;
        if (arm && lk && cmd != 4) return 0;
        return 1;
    endfunction

    function automatic bit cpu_ok(input int cmd, input int page, input bit arm, input bit lk);
        if (cmd < 1 || cmd > 4) return 0;
        if (arm && lk && (cmd == 2 || cmd == 3) && page == 0) return 0;
        return 1;
    endfunction

    task automatic do_reset(input bit arm, input bit kill);
        @(negedge clk);
        rst_n = 1'b0;
        fuse_arm_i = arm;
        fuse_kill_i = kill;
        @(negedge clk);
        rst_n = 1'b1;
        fuse_arm_i = ~arm;
        fuse_kill_i = ~kill;
    endtask

    task automatic lock_write(input bit val);
        @(negedge clk);
        lock_wr_en = 1'b1;
        lock_wr_data = val;
        @(negedge clk);
        lock_wr_en = 1'b0;
        lock_wr_data = 1'b0;
    endtask

    // Full sweep: all command codes and pages on both ports at once.
    task automatic sweep(input string tag, input bit arm, input bit kill, input bit lk);
        for (int c = 0; c < 8; c++) begin
            for (int p = 0; p < (1 << PAGE_W); p++) begin
                bit d, u;
                d = dbg_ok(c, arm, kill, lk);
                u = cpu_ok((c + 3) % 8, p, arm, lk);
                @(negedge clk);
                dbg_req = 1'b1; dbg_cmd = 3'(c); dbg_page = PAGE_W'(p);
                cpu_req = 1'b1; cpu_cmd = 3'((c + 3) % 8); cpu_page = PAGE_W'(p);
                #1;
                chk({tag, " dbg"}, {dbg_grant, dbg_block}, {d, ~d});
                chk({tag, " cpu"}, {cpu_grant, cpu_block}, {u, ~u});
                @(negedge clk);
                dbg_req = 1'b0; cpu_req = 1'b0;
                #1;
                chk("R6 xram_clear", {1'b0, xram_clear},
                    {1'b0, (d && c == 4) || (u && ((c + 3) % 8) == 4)});
                chk("R10 quiet", {dbg_grant | dbg_block, cpu_grant | cpu_block}, 2'b00);
            end
        end
    endtask

    initial begin
        for (int cfg = 0; cfg < 4; cfg++) begin
            bit arm, kill;
            arm = cfg[0];
            kill = cfg[1];
            do_reset(arm, kill);
            @(negedge clk);
            chk("R1 reset xram_clear", {1'b0, xram_clear}, 2'b00);
            // fuse inputs are inverted after reset: R9
            sweep(kill ? "R8 R9 unlocked" : "R1 R9 unlocked", arm, kill, 1'b0);
            lock_write(1'b0);
            sweep("R2 write0", arm, kill, 1'b0);
            lock_write(1'b1);
            sweep(arm ? (kill ? "R8 R5 locked" : "R4 R5 locked") : "R3 lock unarmed",
                  arm, kill, 1'b1);
            lock_write(1'b0);
            sweep("R2 sticky", arm, kill, 1'b1);
            do_reset(arm, kill);
            sweep("R7 after reset", arm, kill, 1'b0);
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule